// File: doc/BRIEF.md
# Out-of-Order Commit Store Queue

This block holds translated stores (address, data and access size) after they leave the load/store pipeline and until they have been written into the data cache. It is a circular queue with six slots by default. Four pointers split the live slots into regions. Stores that have finished execution are waiting for retirement. Retired stores are waiting to be presented to the cache. Presented stores are waiting to be released in order once their write has landed.

Retirement marks the oldest finished store as completed. Only completed stores are presented to the cache, one access per cycle, and the cache answers hit or miss in the same cycle. A store that misses is parked with a pending-miss flag. Younger completed stores keep flowing to the cache while the line reload runs. When the reload engine reports the reloaded slot, the parked store is presented again, ahead of any new store.

Slots are released strictly oldest first, so a parked store holds back the release of everything behind it. A flush removes every store that is still waiting for retirement and keeps every store that has already retired.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `enqReady` is 1 and `reqValid` is 0.
- R2: Up to DEPTH (6) stores are held at once. With DEPTH live slots, `enqReady` is 0, and a store offered in that state is dropped and never presented to the cache.
- R3: A store is presented to the cache only after a `cmplValid` pulse has marked it completed. Each pulse completes the oldest finished store, and a pulse with no finished store has no effect.
- R4: Slots are handed out in ascending order from slot 0 after reset and wrap from DEPTH-1 to 0. Completed stores are presented in program order, at most one per cycle, with `reqTag` set to the store's slot and with its address, data and size.
- R5: A hit on presentation writes the store. Its slot is released on the clock edge after the hitting access, so `enqReady` on a full queue rises one cycle after the hit.
- R6: A store that misses is not presented again until `reloadDone` is pulsed with its slot as `reloadTag`. Until it has been written, no slot from it onward is released, even if younger stores have hit.
- R7: While a miss is outstanding, younger completed stores in other lines are still presented, and a second miss is accepted. With MAX_MISS (2) stores missing or awaiting retry, no new store is presented until one of them has been written.
- R8: A completed store in the same cache line as an outstanding miss is not presented until that miss has been written, and stores behind it wait too. The line is the address above the low log2(LINE_BYTES) = 5 bits.
- R9: A `flush` discards all stores not yet completed and keeps all completed ones. The next store accepted takes the slot right after the youngest completed store. In a flush cycle, `enqValid` and `cmplValid` are ignored.
- R10: A reloaded store is presented ahead of any new store. If it misses again, it waits for another `reloadDone` for its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Translated store offered by the pipeline |
| enqAddr | input | ADDR_W | Store address |
| enqData | input | DATA_W | Store data |
| enqSize | input | SIZE_W | Store access size code |
| enqReady | output | 1 | A slot is free; the offered store is taken |
| cmplValid | input | 1 | Oldest finished store has retired |
| flush | input | 1 | Discard all stores not yet retired |
| reqValid | output | 1 | A store is presented to the cache |
| reqTag | output | 4 | Slot of the presented store |
| reqAddr | output | ADDR_W | Address of the presented store |
| reqData | output | DATA_W | Data of the presented store |
| reqSize | output | SIZE_W | Size code of the presented store |
| cacheHit | input | 1 | Same-cycle cache answer: 1 hit, 0 miss |
| reloadDone | input | 1 | Line reload for a parked store has finished |
| reloadTag | input | 4 | Slot whose reload has finished |

## Verification
The bench builds the block with its defaults: DEPTH 6, MAX_MISS 2 and LINE_BYTES 32. A six-slot ring is not a power of two, so the sequences in the bench reach the slot wrap from 5 to 0 and the full condition with wrapped pointers. A miss limit of two means three stores in distinct lines reach the stall on outstanding misses. The same limit lets a repeated miss on retry be seen while the other miss is still parked. The 32-byte line lets two nearby addresses collide in one line while a third store lies outside it.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Width of a slot index carried between control and datapath (up to 16 slots).
  localparam int SlotW = 4;
  typedef logic [SlotW-1:0] slot_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic  wrEn;    // capture the offered store
    slot_t wrSlot;  // slot receiving it
    slot_t rdSlot;  // slot driven onto the cache request
    slot_t chkSlot; // slot whose line is compared against all others
  } ctl2dp_t;
endpackage

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int LINE_OFF = 5
) (
  input  logic              clk,
  input  ctl2dp_t           ctl,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  input  logic [SIZE_W-1:0] enqSize,
  output logic [DEPTH-1:0]  lineHit,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [SIZE_W-1:0] rdSize
);
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [SIZE_W-1:0] sizeQ [DEPTH];
  logic [LINE_W-1:0] chkLine;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ctl.wrEn && ctl.wrSlot == slot_t'(i)) begin
        addrQ[i] <= enqAddr;
        dataQ[i] <= enqData;
        sizeQ[i] <= enqSize;
      end
    end
  end

  always_comb begin
    rdAddr  = '0;
    rdData  = '0;
    rdSize  = '0;
    chkLine = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ctl.rdSlot == slot_t'(i)) begin
        rdAddr = addrQ[i];
        rdData = dataQ[i];
        rdSize = sizeQ[i];
      end
      if (ctl.chkSlot == slot_t'(i)) chkLine = addrQ[i][ADDR_W-1:LINE_OFF];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign lineHit[i] = (addrQ[i][ADDR_W-1:LINE_OFF] == chkLine);
  end
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int MAX_MISS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enqValid,
  output logic             enqReady,
  input  logic             cmplValid,
  input  logic             flush,
  input  logic             cacheHit,
  input  logic             reloadDone,
  input  slot_t            reloadTag,
  input  logic [DEPTH-1:0] lineHit,
  output logic             reqValid,
  output slot_t            reqTag,
  output ctl2dp_t          ctl
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  slot_t allocPtr, finPtr, issPtr, comPtr;
  logic [CNT_W-1:0] liveCnt, finCnt, waitCnt, issuedCnt, pendCnt;
  logic [CNT_W-1:0] liveNxt, finNxt, waitNxt;
  logic [DEPTH-1:0] written, missWait, retryRdy, pendVec;
  logic [DEPTH-1:0] reqOH, comOH, reloadOH;
  logic enqAcc, cmpAcc, issNew, commitFire, anyRetry, canNew, conflict;
  logic comWritten, comPend;
  slot_t retrySlot, reqSlot;

  function automatic slot_t nextSlot(slot_t s);
    return (s == slot_t'(DEPTH - 1)) ? '0 : s + slot_t'(1);
  endfunction

  assign pendVec   = missWait | retryRdy;
  assign pendCnt   = CNT_W'($countones(pendVec));
  assign issuedCnt = liveCnt - finCnt - waitCnt;
  assign conflict  = |(pendVec & lineHit);

  // Oldest store whose reload has finished, scanning from the release pointer.
  always_comb begin
    anyRetry  = 1'b0;
    retrySlot = comPtr;
    for (int k = 0; k < DEPTH; k++) begin
      int pos;
      pos = int'(comPtr) + k;
      if (pos >= DEPTH) pos = pos - DEPTH;
      for (int i = 0; i < DEPTH; i++) begin
        if (i == pos && retryRdy[i] && !anyRetry) begin
          anyRetry  = 1'b1;
          retrySlot = slot_t'(i);
        end
      end
    end
  end

  assign canNew   = (waitCnt != '0) && (pendCnt < CNT_W'(MAX_MISS)) && !conflict;
  assign reqValid = anyRetry || canNew;
  assign issNew   = !anyRetry && canNew;
  assign reqSlot  = anyRetry ? retrySlot : issPtr;
  assign reqTag   = reqSlot;

  for (genvar i = 0; i < DEPTH; i++) begin : g_oh
    assign reqOH[i]    = (reqSlot == slot_t'(i));
    assign comOH[i]    = (comPtr == slot_t'(i));
    assign reloadOH[i] = (reloadTag == slot_t'(i));
  end

  assign comWritten = |(written & comOH);
  assign comPend    = |(pendVec & comOH);
  assign commitFire = (issuedCnt != '0) && comWritten;

  assign enqReady = (liveCnt != CNT_W'(DEPTH));
  assign enqAcc   = enqValid && enqReady && !flush;
  assign cmpAcc   = cmplValid && !flush && (finCnt != '0);

  assign ctl.wrEn    = enqAcc;
  assign ctl.wrSlot  = allocPtr;
  assign ctl.rdSlot  = reqSlot;
  assign ctl.chkSlot = issPtr;

  always_comb begin
    liveNxt = liveCnt;
    if (enqAcc)     liveNxt = liveNxt + CNT_W'(1);
    if (commitFire) liveNxt = liveNxt - CNT_W'(1);
    if (flush)      liveNxt = liveNxt - finCnt;
    finNxt  = flush ? '0 : finCnt + CNT_W'(enqAcc) - CNT_W'(cmpAcc);
    waitNxt = waitCnt + CNT_W'(cmpAcc) - CNT_W'(issNew);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocPtr <= '0;
      finPtr   <= '0;
      issPtr   <= '0;
      comPtr   <= '0;
      liveCnt  <= '0;
      finCnt   <= '0;
      waitCnt  <= '0;
    end else begin
      if (flush)       allocPtr <= finPtr;
      else if (enqAcc) allocPtr <= nextSlot(allocPtr);
      if (cmpAcc)     finPtr <= nextSlot(finPtr);
      if (issNew)     issPtr <= nextSlot(issPtr);
      if (commitFire) comPtr <= nextSlot(comPtr);
      liveCnt <= liveNxt;
      finCnt  <= finNxt;
      waitCnt <= waitNxt;
    end
  end

  // Per-slot miss tracking and write status.
  for (genvar i = 0; i < DEPTH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        written[i]  <= 1'b0;
        missWait[i] <= 1'b0;
        retryRdy[i] <= 1'b0;
      end else begin
        if (reloadDone && reloadOH[i] && missWait[i]) begin
          missWait[i] <= 1'b0;
          retryRdy[i] <= 1'b1;
        end
        if (reqValid && reqOH[i]) begin
          retryRdy[i] <= 1'b0;
          if (cacheHit) begin
            written[i]  <= 1'b1;
            missWait[i] <= 1'b0;
          end else begin
            missWait[i] <= 1'b1;
          end
        end
        if (commitFire && comOH[i]) written[i] <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt <= CNT_W'(DEPTH)) && ((finCnt + waitCnt) <= liveCnt)); // R2
  AST_REQ_AFTER_CMPL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (liveCnt != finCnt)); // R3
  AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (issuedCnt != '0 && comPend) |=> $stable(comPtr)); // R6
  AST_MISS_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CNT_W'(MAX_MISS)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (finCnt == '0)); // R9
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH      = 6,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SIZE_W     = 2,
  parameter int LINE_BYTES = 32,
  parameter int MAX_MISS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [ADDR_W-1:0] enqAddr,
  input  logic [DATA_W-1:0] enqData,
  input  logic [SIZE_W-1:0] enqSize,
  output logic              enqReady,
  input  logic              cmplValid,
  input  logic              flush,
  output logic              reqValid,
  output logic [SlotW-1:0]  reqTag,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic [SIZE_W-1:0] reqSize,
  input  logic              cacheHit,
  input  logic              reloadDone,
  input  logic [SlotW-1:0]  reloadTag
);
  localparam int LINE_OFF = $clog2(LINE_BYTES);

  ctl2dp_t          ctl;
  logic [DEPTH-1:0] lineHit;

  sq_ctrl #(.DEPTH(DEPTH), .MAX_MISS(MAX_MISS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enqValid  (enqValid),
    .enqReady  (enqReady),
    .cmplValid (cmplValid),
    .flush     (flush),
    .cacheHit  (cacheHit),
    .reloadDone(reloadDone),
    .reloadTag (reloadTag),
    .lineHit   (lineHit),
    .reqValid  (reqValid),
    .reqTag    (reqTag),
    .ctl       (ctl)
  );

  sq_data #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SIZE_W(SIZE_W), .LINE_OFF(LINE_OFF)
  ) u_data (
    .clk    (clk),
    .ctl    (ctl),
    .enqAddr(enqAddr),
    .enqData(enqData),
    .enqSize(enqSize),
    .lineHit(lineHit),
    .rdAddr (reqAddr),
    .rdData (reqData),
    .rdSize (reqSize)
  );
endmodule

// File: tb/store_queue_tb.sv
module store_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int TAG_W = sq_pkg::SlotW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0, cmplValid = 1'b0, flush = 1'b0;
  logic [31:0] enqAddr = '0, enqData = '0;
  logic [1:0] enqSize = '0;
  logic enqReady, reqValid, cacheHit = 1'b0, reloadDone = 1'b0;
  logic [TAG_W-1:0] reqTag, reloadTag = '0;
  logic [31:0] reqAddr, reqData;
  logic [1:0] reqSize;

  store_queue u_dut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqAddr(enqAddr),
    .enqData(enqData), .enqSize(enqSize), .enqReady(enqReady),
    .cmplValid(cmplValid), .flush(flush), .reqValid(reqValid),
    .reqTag(reqTag), .reqAddr(reqAddr), .reqData(reqData), .reqSize(reqSize),
    .cacheHit(cacheHit), .reloadDone(reloadDone), .reloadTag(reloadTag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int          tag;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    bit          hit;
    string       req;
  } item_t;

  item_t expQ[$];
  logic [31:0] slotAddr [DEPTH];
  logic [31:0] slotData [DEPTH];
  logic [1:0]  slotSize [DEPTH];
  int expTag = 0;
  int finModel = 0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int line, int off);
    return {27'(line), 5'(off)};
  endfunction

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic enq(logic [31:0] a, logic [31:0] d, logic [1:0] s, output int tag, output bit acc);
    enqValid = 1'b1; enqAddr = a; enqData = d; enqSize = s;
    acc = enqReady;
    tag = expTag;
    tick();
    enqValid = 1'b0;
    if (acc) begin
      slotAddr[tag] = a; slotData[tag] = d; slotSize[tag] = s;
      expTag = (expTag + 1) % DEPTH;
      finModel++;
    end
  endtask

  task automatic cmpl();
    cmplValid = 1'b1;
    tick();
    cmplValid = 1'b0;
    if (finModel > 0) finModel--;
  endtask

  task automatic doFlush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
    expTag = (expTag - finModel + DEPTH) % DEPTH;
    finModel = 0;
  endtask

  task automatic reload(int tag);
    reloadDone = 1'b1; reloadTag = TAG_W'(tag);
    tick();
    reloadDone = 1'b0;
  endtask

  task automatic expect_req(int tag, bit hit, string req);
    item_t it;
    it.tag = tag; it.addr = slotAddr[tag]; it.data = slotData[tag];
    it.size = slotSize[tag]; it.hit = hit; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compares each cache request with the scoreboard and answers it.
  always @(negedge clk) begin
    if (rstN && reqValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3/R4", "unexpected request tag", longint'(reqTag), -1);
        cacheHit = 1'b1;
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(int'(reqTag) == it.tag, it.req, "request tag", longint'(reqTag), it.tag);
        check(reqAddr == it.addr && reqData == it.data && reqSize == it.size, it.req,
              "request addr/data", {reqAddr, reqData}, {it.addr, it.data});
        cacheHit = it.hit;
      end
    end else begin
      cacheHit = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t, t2, tA, tB, tC, tP, tQ, tR, tU, tV, tW, tF1, tF2, tG;
    int x[3];
    int six[6];
    bit acc;

    tick(3);
    rstN = 1'b1;
    tick();
    // R1: empty after reset
    check(enqReady == 1'b1, "R1", "enqReady after reset", enqReady, 1);
    check(reqValid == 1'b0, "R1", "reqValid after reset", reqValid, 0);

    // R3/R4: basic in-order presentation after completion
    for (int i = 0; i < 3; i++) enq(mk(16 + i, 4), 32'hA000 + i, 2'(i), x[i], acc);
    check(x[0] == 0 && x[2] == 2, "R4", "slots from reset", x[2], 2);
    tick(3);
    check(reqValid == 1'b0, "R3", "no request before completion", reqValid, 0);
    for (int i = 0; i < 3; i++) expect_req(x[i], 1'b1, "R4");
    for (int i = 0; i < 3; i++) cmpl();
    tick(8);
    check(expQ.size() == 0, "R4", "all three presented", expQ.size(), 0);

    // R2: fill to DEPTH with wrap
    for (int i = 0; i < 6; i++) enq(mk(32 + i, 0), 32'hB000 + i, 2'd3, six[i], acc);
    check(six[3] == 0 && six[5] == 2, "R4", "slot wrap 5->0", six[3], 0);
    check(enqReady == 1'b0, "R2", "enqReady when full", enqReady, 0);
    enq(mk(99, 0), 32'hDEAD, 2'd1, t, acc);
    check(acc == 1'b0, "R2", "store dropped when full", acc, 0);
    // R5: release timing after a hit
    expect_req(six[0], 1'b1, "R5");
    cmpl();
    tick();
    check(enqReady == 1'b0, "R5", "not released on hit edge", enqReady, 0);
    tick();
    check(enqReady == 1'b1, "R5", "released one cycle after hit", enqReady, 1);
    enq(mk(40, 0), 32'hC0DE, 2'd2, t, acc);
    check(acc == 1'b1 && t == six[0], "R4", "reused released slot", t, six[0]);
    for (int i = 1; i < 6; i++) expect_req(six[i], 1'b1, "R2");
    expect_req(t, 1'b1, "R2");
    for (int i = 0; i < 6; i++) cmpl();
    tick(10);
    check(expQ.size() == 0, "R2", "full queue drained without dropped store", expQ.size(), 0);

    // R3: completion with nothing finished is ignored
    cmpl();
    tick(3);
    enq(mk(41, 0), 32'hE1, 2'd0, t, acc);
    tick(4);
    check(reqValid == 1'b0, "R3", "stray completion ignored", reqValid, 0);
    expect_req(t, 1'b1, "R3");
    cmpl();
    tick(6);

    // R6: miss parks, younger hit, release blocked
    enq(mk(50, 0), 32'hF0, 2'd2, tA, acc);
    enq(mk(51, 0), 32'hF1, 2'd2, tB, acc);
    enq(mk(52, 0), 32'hF2, 2'd2, tC, acc);
    expect_req(tA, 1'b0, "R6");
    expect_req(tB, 1'b1, "R7");
    expect_req(tC, 1'b1, "R7");
    for (int i = 0; i < 3; i++) cmpl();
    tick(8);
    check(expQ.size() == 0 && reqValid == 1'b0, "R6", "parked store not re-presented", reqValid, 0);
    for (int i = 0; i < 3; i++) enq(mk(60 + i, 0), 32'h100 + i, 2'd1, x[i], acc);
    check(enqReady == 1'b0, "R6", "younger hits not released", enqReady, 0);
    expect_req(tA, 1'b1, "R10");
    reload(tA);
    tick(8);
    check(enqReady == 1'b1, "R6", "released after retry write", enqReady, 1);
    for (int i = 0; i < 3; i++) expect_req(x[i], 1'b1, "R6");
    for (int i = 0; i < 3; i++) cmpl();
    tick(8);

    // R7/R10: miss limit and repeated miss
    enq(mk(70, 0), 32'h70, 2'd0, tP, acc);
    enq(mk(71, 0), 32'h71, 2'd0, tQ, acc);
    enq(mk(72, 0), 32'h72, 2'd0, tR, acc);
    expect_req(tP, 1'b0, "R7");
    expect_req(tQ, 1'b0, "R7");
    for (int i = 0; i < 3; i++) cmpl();
    tick(6);
    check(reqValid == 1'b0 && expQ.size() == 0, "R7", "held at miss limit", reqValid, 0);
    expect_req(tQ, 1'b0, "R10");
    reload(tQ);
    tick(4);
    check(reqValid == 1'b0 && expQ.size() == 0, "R10", "repeat miss waits again", reqValid, 0);
    expect_req(tQ, 1'b1, "R10");
    expect_req(tR, 1'b1, "R7");
    reload(tQ);
    tick(4);
    check(expQ.size() == 0, "R7", "new store after miss resolved", expQ.size(), 0);
    expect_req(tP, 1'b1, "R10");
    reload(tP);
    tick(8);

    // R8: same-line store held behind outstanding miss
    enq(mk(80, 0), 32'h80, 2'd2, tU, acc);
    enq(mk(80, 8), 32'h81, 2'd2, tV, acc);
    enq(mk(81, 0), 32'h82, 2'd2, tW, acc);
    expect_req(tU, 1'b0, "R8");
    for (int i = 0; i < 3; i++) cmpl();
    tick(6);
    check(reqValid == 1'b0 && expQ.size() == 0, "R8", "same-line store held", reqValid, 0);
    expect_req(tU, 1'b1, "R8");
    expect_req(tV, 1'b1, "R8");
    expect_req(tW, 1'b1, "R8");
    reload(tU);
    tick(8);

    // R9: flush keeps completed, drops finished
    enq(mk(90, 0), 32'h90, 2'd1, tF1, acc);
    enq(mk(91, 0), 32'h91, 2'd1, tF2, acc);
    enq(mk(92, 0), 32'h92, 2'd1, t, acc);
    enq(mk(93, 0), 32'h93, 2'd1, t2, acc);
    expect_req(tF1, 1'b1, "R9");
    expect_req(tF2, 1'b1, "R9");
    cmpl();
    cmpl();
    doFlush();
    enq(mk(94, 0), 32'h94, 2'd3, tG, acc);
    check(tG == (tF2 + 1) % DEPTH, "R9", "slot after youngest completed", tG, (tF2 + 1) % DEPTH);
    expect_req(tG, 1'b1, "R9");
    cmpl();
    cmpl();
    tick(8);
    check(expQ.size() == 0, "R9", "completed stores kept", expQ.size(), 0);
    check(enqReady == 1'b1 && reqValid == 1'b0, "R9", "flushed stores gone", reqValid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule